// File: doc/BRIEF.md
# Fractional-N Divider Modulus Controller

This block is the digital half of a fractional-N frequency synthesizer. It counts edges of the oscillator clock and issues a feedback tick once per divider period. The length of each period is an integer ratio, plus one extra count in the periods where a first-order phase accumulator overflows. A 20-bit fraction word, scaled by 2^20, is added to the accumulator once per feedback period. At a comparison rate near 24 MHz this gives a frequency step of about 23 Hz. A mode input turns the accumulator off for plain integer division.

The block also divides the reference pulse stream by one or two to make the comparison tick. It makes a buffered-reference tick that is either full or half rate, and an LO post-divider tick at one quarter or one eighth of the oscillator rate. A test selector routes either divided signal to a single observation pin. Both clocks arrive as one-cycle strobes (`vcoPulse`, `refPulse`) in the block's own clock domain. Every divider reads its ratio only at its own period boundary, so a reprogrammed ratio never cuts a period short.

Top module: `fracNModulus`

## Requirements
- R1: While `rstN` is low, all tick outputs and `testOut` are 0 and `divModulus` is 4. The first period of each divider after reset uses its reset ratio: 4 oscillator pulses for the main divider, 1 reference pulse for the comparison and buffered-reference dividers, and 4 oscillator pulses for the LO divider.
- R2: With `fracEn` = 0, every main-divider period lasts exactly the effective integer ratio in `vcoPulse` strobes, whatever `fracWord` holds. The accumulator is held at zero.
- R3: With `fracEn` = 1, at each main-divider boundary the 20-bit accumulator takes (acc + `fracWord`) mod 2^20. The next period lasts the effective integer ratio plus the carry out of that 20-bit sum.
- R4: An `intRatio` below 4 is used as 4, so a period never spans fewer than 4 oscillator pulses.
- R5: `divModulus` shows the ratio of the main-divider period now running. It changes only in the cycle after a boundary. Ratio, fraction and mode inputs are sampled only at a boundary.
- R6: `compTick` marks every `refPulse` when `compDiv2` = 0 and every second one when it is 1. The select is sampled at this divider's boundary.
- R7: `refOutTick` marks every `refPulse` when `refOutHalf` = 0 and every second one when it is 1. It has its own counter and its select is sampled at its own boundary.
- R8: `loTick` marks every 4th `vcoPulse` when `loDiv8` = 0 and every 8th when it is 1. The select is sampled at the LO boundary.
- R9: `testOut` equals `divTick` when `testSel` = 3'b001, equals `compTick` when `testSel` = 3'b010, and is 0 for every other code, including 3'b000 (normal) and 3'b011 (reserved).
- R10: Each tick is high for one cycle. It rises in the cycle after the input strobe that completes its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vcoPulse | input | 1 | One-cycle strobe per oscillator edge |
| refPulse | input | 1 | One-cycle strobe per reference edge |
| intRatio | input | 7 | Integer part of the main ratio |
| fracWord | input | 20 | Fractional part times 2^20 |
| fracEn | input | 1 | 1 = fractional mode, 0 = integer mode |
| compDiv2 | input | 1 | Reference pre-divider: 0 = /1, 1 = /2 |
| refOutHalf | input | 1 | Buffered reference: 0 = full rate, 1 = half rate |
| loDiv8 | input | 1 | LO post-divider: 0 = /4, 1 = /8 |
| testSel | input | 3 | Observation select (see R9) |
| divTick | output | 1 | Main feedback divider tick |
| compTick | output | 1 | Comparison (reference-divider) tick |
| refOutTick | output | 1 | Buffered reference tick |
| loTick | output | 1 | LO post-divider tick |
| testOut | output | 1 | Observation output |
| divModulus | output | 8 | Ratio of the main period now running |

## Verification
A corrupted accumulator or a wrong carry shows up as a main-divider period one pulse too long or too short. This appears at the next `divTick`, and `divModulus` shows the wrong value in the cycle after that boundary. A ratio that is sampled early makes a period of the wrong length at once, in the middle of the period where the input changed. This is visible because the bench changes the configuration at random moments. Errors in the reference and LO counters show up as a wrong pulse count between two ticks of that divider.

// File: rtl/fracNModulusPkg.sv
package fracNModulusPkg;

  typedef struct packed {
    logic mainWrap;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    TST_OFF  = 3'b000,
    TST_MAIN = 3'b001,
    TST_REF  = 3'b010
  } testSel_e;

endpackage

// File: rtl/pulseDivider.sv
module pulseDivider #(
  parameter int W       = 4,
  parameter bit LATCH   = 1'b1,
  parameter int RST_MOD = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic [W-1:0] modIn,
  output logic         wrap,
  output logic         tick
);

  logic [W-1:0] cnt;
  logic [W-1:0] modUse;

  generate
    if (LATCH) begin : gLatch
      logic [W-1:0] modQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) modQ <= W'(RST_MOD);
        else if (wrap) modQ <= modIn;
      end
      assign modUse = modQ;
    end else begin : gDirect
      assign modUse = modIn;
    end
  endgenerate

  assign wrap = en && (cnt == modUse - W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (en) cnt <= wrap ? '0 : cnt + W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt < modUse); // R5
  AST_TICK_AFTER_EN: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(en)); // R10

endmodule

// File: rtl/fracNModDatapath.sv
module fracNModDatapath
  import fracNModulusPkg::*;
#(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 20,
  parameter int MIN_N  = 4,
  localparam int MOD_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [INT_W-1:0]  intRatio,
  input  logic [FRAC_W-1:0] fracWord,
  input  logic              fracEn,
  output logic [MOD_W-1:0]  curModulus
);

  logic [FRAC_W-1:0] accQ;
  logic [FRAC_W:0]   sum;
  logic [MOD_W-1:0]  effN;
  logic [MOD_W-1:0]  nextMod;

  always_comb begin
    effN = ({1'b0, intRatio} < MOD_W'(MIN_N)) ? MOD_W'(MIN_N) : {1'b0, intRatio};
    sum  = {1'b0, accQ} + {1'b0, fracWord};
    nextMod = effN + (fracEn ? MOD_W'(sum[FRAC_W]) : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ       <= '0;
      curModulus <= MOD_W'(MIN_N);
    end else if (strobe.mainWrap) begin
      accQ       <= fracEn ? sum[FRAC_W-1:0] : '0;
      curModulus <= nextMod;
    end
  end

  AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.mainWrap |=> $stable(curModulus)); // R5
  AST_MOD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    curModulus >= MOD_W'(MIN_N)); // R4

endmodule

// File: rtl/fracNModCtrl.sv
module fracNModCtrl
  import fracNModulusPkg::*;
#(
  parameter int MOD_W = 8,
  parameter int MIN_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vcoPulse,
  input  logic             refPulse,
  input  logic [MOD_W-1:0] curModulus,
  input  logic             compDiv2,
  input  logic             refOutHalf,
  input  logic             loDiv8,
  output ctrlStrobe_t      strobe,
  output logic             divTick,
  output logic             compTick,
  output logic             refOutTick,
  output logic             loTick
);

  logic mainWrap, compWrap, refOutWrap, loWrap;

  pulseDivider #(.W(MOD_W), .LATCH(1'b0), .RST_MOD(MIN_N)) uMain (
    .clk(clk), .rstN(rstN), .en(vcoPulse), .modIn(curModulus),
    .wrap(mainWrap), .tick(divTick));

  pulseDivider #(.W(2), .LATCH(1'b1), .RST_MOD(1)) uComp (
    .clk(clk), .rstN(rstN), .en(refPulse), .modIn(compDiv2 ? 2'd2 : 2'd1),
    .wrap(compWrap), .tick(compTick));

  pulseDivider #(.W(2), .LATCH(1'b1), .RST_MOD(1)) uRefOut (
    .clk(clk), .rstN(rstN), .en(refPulse), .modIn(refOutHalf ? 2'd2 : 2'd1),
    .wrap(refOutWrap), .tick(refOutTick));

  pulseDivider #(.W(4), .LATCH(1'b1), .RST_MOD(4)) uLo (
    .clk(clk), .rstN(rstN), .en(vcoPulse), .modIn(loDiv8 ? 4'd8 : 4'd4),
    .wrap(loWrap), .tick(loTick));

  assign strobe.mainWrap = mainWrap;

  AST_LO_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    loTick |=> !loTick); // R8
  AST_COMP_NEEDS_REF: assert property (@(posedge clk) disable iff (!rstN)
    compWrap |-> refPulse); // R6
  AST_REFOUT_NEEDS_REF: assert property (@(posedge clk) disable iff (!rstN)
    refOutWrap |-> refPulse); // R7
  AST_LO_NEEDS_VCO: assert property (@(posedge clk) disable iff (!rstN)
    loWrap |-> vcoPulse); // R8

endmodule

// File: rtl/fracNModulus.sv
module fracNModulus
  import fracNModulusPkg::*;
#(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 20,
  parameter int MIN_N  = 4,
  localparam int MOD_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoPulse,
  input  logic              refPulse,
  input  logic [INT_W-1:0]  intRatio,
  input  logic [FRAC_W-1:0] fracWord,
  input  logic              fracEn,
  input  logic              compDiv2,
  input  logic              refOutHalf,
  input  logic              loDiv8,
  input  logic [2:0]        testSel,
  output logic              divTick,
  output logic              compTick,
  output logic              refOutTick,
  output logic              loTick,
  output logic              testOut,
  output logic [MOD_W-1:0]  divModulus
);

  ctrlStrobe_t strobe;

  fracNModCtrl #(.MOD_W(MOD_W), .MIN_N(MIN_N)) uCtrl (
    .clk(clk), .rstN(rstN), .vcoPulse(vcoPulse), .refPulse(refPulse),
    .curModulus(divModulus), .compDiv2(compDiv2), .refOutHalf(refOutHalf),
    .loDiv8(loDiv8), .strobe(strobe), .divTick(divTick), .compTick(compTick),
    .refOutTick(refOutTick), .loTick(loTick));

  fracNModDatapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_N(MIN_N)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intRatio(intRatio),
    .fracWord(fracWord), .fracEn(fracEn), .curModulus(divModulus));

  always_comb begin
    case (testSel)
      TST_MAIN: testOut = divTick;
      TST_REF:  testOut = compTick;
      default:  testOut = 1'b0;
    endcase
  end

  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (testSel != TST_MAIN && testSel != TST_REF) |-> !testOut); // R9
  AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    divTick |=> !divTick); // R10

endmodule

// File: tb/fracNModulus_test.sv
module fracNModulus_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        vcoPulse = 1'b0, refPulse = 1'b0;
  logic [6:0]  intRatio = 7'd10;
  logic [19:0] fracWord = '0;
  logic        fracEn = 1'b0, compDiv2 = 1'b0, refOutHalf = 1'b0, loDiv8 = 1'b0;
  logic [2:0]  testSel = 3'b000;
  logic        divTick, compTick, refOutTick, loTick, testOut;
  logic [7:0]  divModulus;

  fracNModulus uut (
    .clk(clk), .rstN(rstN), .vcoPulse(vcoPulse), .refPulse(refPulse),
    .intRatio(intRatio), .fracWord(fracWord), .fracEn(fracEn),
    .compDiv2(compDiv2), .refOutHalf(refOutHalf), .loDiv8(loDiv8),
    .testSel(testSel), .divTick(divTick), .compTick(compTick),
    .refOutTick(refOutTick), .loTick(loTick), .testOut(testOut),
    .divModulus(divModulus));

  int checks = 0, fails = 0;
  bit monOn = 1'b0, done = 1'b0;
  int expMod[4];
  int pulseCnt[4];
  int lastCnt[4];
  logic [19:0] accModel;

  function automatic int effN(int n);
    return (n < 4) ? 4 : n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: samples 1 ns after each rising edge, inputs still hold edge values.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monOn) begin
        logic [3:0] ticks;
        logic [20:0] sum;
        int expTest;
        ticks = {loTick, refOutTick, compTick, divTick};
        pulseCnt[0] += int'(vcoPulse);
        pulseCnt[3] += int'(vcoPulse);
        pulseCnt[1] += int'(refPulse);
        pulseCnt[2] += int'(refPulse);
        for (int i = 0; i < 4; i++) begin
          if (ticks[i]) begin
            case (i)
              0: check("R2 R3 R4 R10 main period", pulseCnt[i] - lastCnt[i], expMod[i]);
              1: check("R6 R10 comparison period", pulseCnt[i] - lastCnt[i], expMod[i]);
              2: check("R7 buffered reference period", pulseCnt[i] - lastCnt[i], expMod[i]);
              default: check("R8 LO period", pulseCnt[i] - lastCnt[i], expMod[i]);
            endcase
            lastCnt[i] = pulseCnt[i];
            case (i)
              0: begin
                if (fracEn) begin
                  sum = {1'b0, accModel} + {1'b0, fracWord};
                  accModel = sum[19:0];
                  expMod[0] = effN(int'(intRatio)) + int'(sum[20]);
                end else begin
                  accModel = '0;
                  expMod[0] = effN(int'(intRatio));
                end
              end
              1: expMod[1] = compDiv2 ? 2 : 1;
              2: expMod[2] = refOutHalf ? 2 : 1;
              default: expMod[3] = loDiv8 ? 8 : 4;
            endcase
          end
        end
        check("R5 divModulus", int'(divModulus), expMod[0]);
        case (testSel)
          3'b001:  expTest = int'(divTick);
          3'b010:  expTest = int'(compTick);
          default: expTest = 0;
        endcase
        check("R9 testOut", int'(testOut), expTest);
      end
    end
  end

  task automatic runPhase(int cycles, int vcoDens, int refDens);
    repeat (cycles) begin
      @(negedge clk);
      vcoPulse = (($urandom % 100) < vcoDens);
      refPulse = (($urandom % 100) < refDens);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 divTick in reset", int'(divTick), 0);
    check("R1 compTick in reset", int'(compTick), 0);
    check("R1 refOutTick in reset", int'(refOutTick), 0);
    check("R1 loTick in reset", int'(loTick), 0);
    check("R1 testOut in reset", int'(testOut), 0);
    check("R1 divModulus in reset", int'(divModulus), 4);
    expMod[0] = 4; expMod[1] = 1; expMod[2] = 1; expMod[3] = 4;
    for (int i = 0; i < 4; i++) begin
      pulseCnt[i] = 0;
      lastCnt[i] = 0;
    end
    accModel = '0;
    intRatio = 7'd10; fracWord = 20'h12345; fracEn = 1'b0; testSel = 3'b001;
    rstN = 1'b1;
    monOn = 1'b1;
    // R2 integer mode ignores fraction
    runPhase(200, 100, 50);
    // R3 half fraction alternates N and N+1, also R6 /2 and R8 /8
    @(negedge clk);
    intRatio = 7'd20; fracWord = 20'h80000; fracEn = 1'b1;
    testSel = 3'b010; loDiv8 = 1'b1; compDiv2 = 1'b1; refOutHalf = 1'b1;
    runPhase(400, 100, 70);
    // R4 small ratio clamped, near-full fraction
    @(negedge clk);
    intRatio = 7'd2; fracWord = 20'hFFFFF;
    runPhase(200, 80, 60);
    // R4 zero ratio, integer mode, reserved test code (R9)
    @(negedge clk);
    intRatio = 7'd0; fracEn = 1'b0; testSel = 3'b011;
    runPhase(150, 100, 100);
    // largest ratio with carry
    @(negedge clk);
    intRatio = 7'd127; fracWord = 20'hFFFFF; fracEn = 1'b1; testSel = 3'b001;
    runPhase(700, 100, 30);
    // random mix, reconfiguring mid-period (R5)
    for (int b = 0; b < 40; b++) begin
      @(negedge clk);
      intRatio   = 7'($urandom % 128);
      fracWord   = 20'($urandom);
      fracEn     = 1'($urandom % 2);
      compDiv2   = 1'($urandom % 2);
      refOutHalf = 1'($urandom % 2);
      loDiv8     = 1'($urandom % 2);
      testSel    = 3'($urandom % 8);
      runPhase(250, 20 + int'($urandom % 81), 20 + int'($urandom % 81));
    end
    @(negedge clk);
    vcoPulse = 1'b0; refPulse = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule